// File: doc/BRIEF.md
# MDIO Management Master

This block is a memory-mapped master for the two-wire PHY management bus. Software places a value in a data register and a command in a control register; setting the go bit launches one management frame, and the busy flag in the same control register stays high until the last bit has left the wire. The block generates the management clock from the system clock at one of five selectable rates and drives or samples the data line through an output, an output enable and an input.

Both the original short-form framing and the extended (indirect, device-addressed) framing are supported from the same control register. In the extended form a register access takes two frames: an address frame that carries the 16-bit register number from the data register, followed by a write, read or read-with-increment frame. Read frames release the line for the turnaround and the data field, and the 16 bits the PHY returns are placed in the data register with the upper half cleared.

Top module: `mdio_mgmt_top`

## Requirements
- R1: After reset, the control register reads 0 (busy clear), the data register reads 0, `mdc` is low and `mdio_oe` is low.
- R2: A control write (offset 0x120) with bit 0 set starts one frame; bit 0 of the control register reads 1 for exactly 128 half-periods of the management clock, i.e. 64 clock periods, and then reads 0.
- R3: Every frame opens with 32 ones, then a start pair of 01 (short form, bit 3 clear) or 00 (extended form, bit 3 set); in the short form the opcode is 01 when control bit 1 is set and 10 when it is clear.
- R4: After the opcode the frame carries the PHY address from control bits 15:11 and then the register index (short form) or device address (extended form) from control bits 10:6, each five bits, most significant bit first.
- R5: Non-read frames drive a turnaround of 10 followed by bits 15:0 of the data register (offset 0x124), most significant first, with `mdio_oe` high for all 64 bits.
- R6: Read frames drive `mdio_oe` only for the first 46 bits and release it for the turnaround and data; `mdio` is sampled at each rising edge of `mdc` during the 16 data bits and the data register then reads those bits in 15:0 with 31:16 zero.
- R7: In the extended form the command field (control bits 2:1) maps to the opcode as 00→00 (address), 01→01 (write), 10→11 (read), 11→10 (read with increment); the address and write commands are non-read frames and the two read commands are read frames.
- R8: The `mdc` half-period in system clocks follows control bits 18:16: 0→25, 1→13, 2→5, 3→3, 4→50, and 5, 6, 7→50; `mdio_o` never changes while `mdc` is high.
- R9: A control write while busy is set has no effect: the running frame, its length and the control fields read back are unchanged, and no further frame follows.
- R10: While no frame runs, `mdio_oe` is low and `mdc` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W (12) | Register byte offset for write and read |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for `bus_addr` (combinational) |
| mdc | output | 1 | Management clock to the PHYs |
| mdio_o | output | 1 | Management data driven by the master |
| mdio_oe | output | 1 | Drive enable for `mdio_o`; low means high impedance |
| mdio_i | input | 1 | Management data seen on the line |

## Verification
The assertions take for granted that software only writes the control register at one of the two decoded offsets and that the PHY changes `mdio_i` only while `mdc` is low, so that the sample taken at the rising edge is settled. The bench's PHY responder changes its data only on falling edges of `mdc`, and all register traffic is applied at falling system-clock edges through a single write task. A control write during a frame is made on purpose in one scenario, where the assertion that guards it expects the fields to hold.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    localparam int FRAME_BITS = 64;
    localparam int TA_FIRST   = 46;
    localparam int DATA_FIRST = 48;

    typedef enum logic [1:0] {
        XCMD_ADDR     = 2'b00,
        XCMD_WRITE    = 2'b01,
        XCMD_READ     = 2'b10,
        XCMD_READ_INC = 2'b11
    } xcmd_e;

    typedef struct packed {
        logic [2:0] rate;
        logic [4:0] phy;
        logic [4:0] regad;
        logic       ext;
        logic [1:0] cmd;
    } ctrl_t;

    function automatic ctrl_t unpack_ctrl(input logic [31:0] w);
        ctrl_t c;
        c.rate  = w[18:16];
        c.phy   = w[15:11];
        c.regad = w[10:6];
        c.ext   = w[3];
        c.cmd   = w[2:1];
        return c;
    endfunction

    function automatic logic [31:0] pack_ctrl(input ctrl_t c, input logic busy);
        return {13'd0, c.rate, c.phy, c.regad, 2'b00, c.ext, c.cmd, busy};
    endfunction

    function automatic logic frame_is_read(input ctrl_t c);
        if (c.ext) return c.cmd[1];
        return !c.cmd[0];
    endfunction

    function automatic logic [1:0] frame_opcode(input ctrl_t c);
        logic [1:0] op;
        if (!c.ext) begin
            op = c.cmd[0] ? 2'b01 : 2'b10;
        end else begin
            case (xcmd_e'(c.cmd))
                XCMD_ADDR:     op = 2'b00;
                XCMD_WRITE:    op = 2'b01;
                XCMD_READ:     op = 2'b11;
                default:       op = 2'b10;
            endcase
        end
        return op;
    endfunction

    function automatic logic [FRAME_BITS-1:0] build_frame(input ctrl_t c, input logic [15:0] wd);
        logic [1:0] st;
        st = c.ext ? 2'b00 : 2'b01;
        return {32'hFFFF_FFFF, st, frame_opcode(c), c.phy, c.regad, 2'b10, wd};
    endfunction

    function automatic int mdc_rate_hz(input int sel);
        case (sel)
            0:       return 2_500_000;
            1:       return 5_000_000;
            2:       return 12_500_000;
            3:       return 25_000_000;
            default: return 1_250_000;
        endcase
    endfunction

    function automatic int half_clocks(input int sys_hz, input int sel);
        int hz;
        int h;
        hz = mdc_rate_hz(sel);
        h  = (sys_hz + 2 * hz - 1) / (2 * hz);
        return (h < 1) ? 1 : h;
    endfunction

endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
    parameter int HALF_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic [HALF_W-1:0] half,
    output logic              mdc,
    output logic              rise,
    output logic              fall
);

    logic [HALF_W-1:0] cnt;
    logic              wrap;

    assign wrap = run && (cnt == half - 1'b1);
    assign rise = wrap && !mdc;
    assign fall = wrap && mdc;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (wrap) begin
            cnt <= '0;
            mdc <= ~mdc;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // R10: clock parks low once the frame stops
    p_mdc_parks_low_r10: assert property (@(posedge clk) disable iff (rst)
        !run |=> !mdc);

    // R8: the divider count stays inside the selected half period
    p_cnt_in_range_r8: assert property (@(posedge clk) disable iff (rst)
        (run && $stable(half)) |-> (cnt < half));

endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
    import mdio_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  ctrl_t       ctrl,
    input  logic [15:0] wdata,
    input  logic        rise,
    input  logic        fall,
    input  logic        mdio_i,
    output logic        busy,
    output logic        mdio_o,
    output logic        mdio_oe,
    output logic        rd_done,
    output logic [15:0] rx_data
);

    localparam int IDX_W = $clog2(FRAME_BITS);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BITS - 1);
    localparam logic [IDX_W-1:0] TA_IDX   = IDX_W'(TA_FIRST);
    localparam logic [IDX_W-1:0] DATA_IDX = IDX_W'(DATA_FIRST);

    logic [FRAME_BITS-1:0] frame_q;
    logic [FRAME_BITS-1:0] frame_new;
    logic [IDX_W-1:0]      idx;
    logic [IDX_W-1:0]      nxt_idx;
    logic [IDX_W-1:0]      nxt_pos;
    logic                  rd_q;
    logic [15:0]           shreg;

    assign frame_new = build_frame(ctrl, wdata);
    assign nxt_idx   = idx + 1'b1;
    assign nxt_pos   = LAST_IDX - nxt_idx;
    assign rx_data   = shreg;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b0;
            idx     <= '0;
            frame_q <= '0;
            rd_q    <= 1'b0;
            shreg   <= '0;
            mdio_o  <= 1'b1;
            mdio_oe <= 1'b0;
            rd_done <= 1'b0;
        end else begin
            rd_done <= 1'b0;
            if (!busy) begin
                if (start) begin
                    busy    <= 1'b1;
                    idx     <= '0;
                    frame_q <= frame_new;
                    rd_q    <= frame_is_read(ctrl);
                    mdio_o  <= frame_new[FRAME_BITS-1];
                    mdio_oe <= 1'b1;
                end
            end else begin
                if (rise && rd_q && (idx >= DATA_IDX)) begin
                    shreg <= {shreg[14:0], mdio_i};
                end
                if (fall) begin
                    if (idx == LAST_IDX) begin
                        busy    <= 1'b0;
                        mdio_o  <= 1'b1;
                        mdio_oe <= 1'b0;
                        rd_done <= rd_q;
                    end else begin
                        idx     <= nxt_idx;
                        mdio_o  <= frame_q[nxt_pos];
                        mdio_oe <= !(rd_q && (nxt_idx >= TA_IDX));
                    end
                end
            end
        end
    end

    // R10: line released whenever no frame runs
    p_oe_idle_r10: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mdio_oe);

    // R2: a frame only ends after its last bit
    p_end_on_last_r2: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> ($past(idx) == LAST_IDX));

    // R6: read frames keep the line released through turnaround and data
    p_read_release_r6: assert property (@(posedge clk) disable iff (rst)
        (busy && rd_q && idx >= TA_IDX) |-> !mdio_oe);

    // R5: non-read frames keep driving for the whole frame
    p_write_drive_r5: assert property (@(posedge clk) disable iff (rst)
        (busy && !rd_q) |-> mdio_oe);

endmodule

// File: rtl/mdio_mgmt_top.sv
module mdio_mgmt_top
    import mdio_pkg::*;
#(
    parameter int          SYS_CLK_HZ = 125_000_000,
    parameter int          ADDR_W     = 12,
    parameter logic [11:0] CTRL_OFS   = 12'h120,
    parameter logic [11:0] DATA_OFS   = 12'h124
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              mdc,
    output logic              mdio_o,
    output logic              mdio_oe,
    input  logic              mdio_i
);

    localparam int H_R0   = half_clocks(SYS_CLK_HZ, 0);
    localparam int H_R1   = half_clocks(SYS_CLK_HZ, 1);
    localparam int H_R2   = half_clocks(SYS_CLK_HZ, 2);
    localparam int H_R3   = half_clocks(SYS_CLK_HZ, 3);
    localparam int H_SLOW = half_clocks(SYS_CLK_HZ, 4);
    localparam int HALF_W = $clog2(H_SLOW + 1);
    localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_OFS);
    localparam logic [ADDR_W-1:0] DATA_A = ADDR_W'(DATA_OFS);

    ctrl_t             ctrl_q;
    ctrl_t             ctrl_wr;
    logic [31:0]       data_q;
    logic              busy;
    logic              ctrl_hit;
    logic              data_hit;
    logic              ctrl_take;
    logic              start;
    logic [HALF_W-1:0] half;
    logic              rise;
    logic              fall;
    logic              rd_done;
    logic [15:0]       rx_data;

    assign ctrl_wr   = unpack_ctrl(bus_wdata);
    assign ctrl_hit  = bus_wr && (bus_addr == CTRL_A);
    assign data_hit  = bus_wr && (bus_addr == DATA_A);
    assign ctrl_take = ctrl_hit && !busy;
    assign start     = ctrl_take && bus_wdata[0];

    always_comb begin
        case (ctrl_q.rate)
            3'd0:    half = HALF_W'(H_R0);
            3'd1:    half = HALF_W'(H_R1);
            3'd2:    half = HALF_W'(H_R2);
            3'd3:    half = HALF_W'(H_R3);
            default: half = HALF_W'(H_SLOW);
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            data_q <= '0;
        end else begin
            if (ctrl_take) begin
                ctrl_q <= ctrl_wr;
            end
            if (rd_done) begin
                data_q <= {16'd0, rx_data};
            end else if (data_hit) begin
                data_q <= bus_wdata;
            end
        end
    end

    always_comb begin
        if (bus_addr == CTRL_A) begin
            bus_rdata = pack_ctrl(ctrl_q, busy);
        end else if (bus_addr == DATA_A) begin
            bus_rdata = data_q;
        end else begin
            bus_rdata = '0;
        end
    end

    mdio_mdc_gen #(
        .HALF_W (HALF_W)
    ) u_clkgen (
        .clk  (clk),
        .rst  (rst),
        .run  (busy),
        .half (half),
        .mdc  (mdc),
        .rise (rise),
        .fall (fall)
    );

    mdio_frame_engine u_engine (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .ctrl    (ctrl_wr),
        .wdata   (data_q[15:0]),
        .rise    (rise),
        .fall    (fall),
        .mdio_i  (mdio_i),
        .busy    (busy),
        .mdio_o  (mdio_o),
        .mdio_oe (mdio_oe),
        .rd_done (rd_done),
        .rx_data (rx_data)
    );

    // R9: control writes during a frame leave the fields alone
    p_busy_write_ignored_r9: assert property (@(posedge clk) disable iff (rst)
        (busy && ctrl_hit) |=> (ctrl_q == $past(ctrl_q)));

    // R8: data only moves while the management clock is low
    p_mdio_steady_high_r8: assert property (@(posedge clk) disable iff (rst)
        mdc |-> $stable(mdio_o));

    // R6: captured read data never carries an upper half
    p_rx_upper_zero_r6: assert property (@(posedge clk) disable iff (rst)
        rd_done |=> (data_q[31:16] == 16'd0));

endmodule

// File: tb/mdio_mgmt_top_bench.sv
module mdio_mgmt_top_bench;

    localparam logic [11:0] CTRL_A = 12'h120;
    localparam logic [11:0] DATA_A = 12'h124;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = CTRL_A;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        mdc;
    logic        mdio_o;
    logic        mdio_oe;
    logic        mdio_i = 1'b1;

    int checks = 0;
    int failures = 0;

    logic [63:0] cap;
    logic [63:0] oecap;
    logic [15:0] resp = '0;
    int          nrise = 0;
    int          seg_min;
    int          seg_max;
    int          seg_len;
    bit          seg_first;
    logic        mdc_prev = 1'b0;

    always #5 clk = ~clk;

    mdio_mgmt_top u_mdio_mgmt_top (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .mdc       (mdc),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe),
        .mdio_i    (mdio_i)
    );

    // PHY side: record each bit at the rising edge
    initial forever begin
        @(posedge mdc);
        if (nrise < 64) begin
            cap[63 - nrise]   = mdio_o;
            oecap[63 - nrise] = mdio_oe;
        end
        nrise++;
    end

    // PHY side: present read data after each falling edge
    initial forever begin
        @(negedge mdc);
        if (nrise >= 48 && nrise <= 63) mdio_i = resp[63 - nrise];
        else mdio_i = 1'b1;
    end

    // management clock half-period measurement
    initial forever begin
        @(negedge clk);
        if (mdc !== mdc_prev) begin
            if (!seg_first) begin
                if (seg_len < seg_min) seg_min = seg_len;
                if (seg_len > seg_max) seg_max = seg_len;
            end
            seg_first = 1'b0;
            seg_len = 1;
        end else begin
            seg_len++;
        end
        mdc_prev = mdc;
    end

    initial begin
        #1_500_000;
        failures++;
        checks++;
        $display("FAIL watchdog: run did not complete (actual hung, expected finish)");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mkctl(input logic [2:0] rate, input logic [4:0] phy,
                                          input logic [4:0] rg, input logic ext, input logic [1:0] cmd);
        return {13'd0, rate, phy, rg, 2'b00, ext, cmd, 1'b1};
    endfunction

    function automatic logic [63:0] expfrm(input logic [1:0] st, input logic [1:0] op,
                                           input logic [4:0] phy, input logic [4:0] rg, input logic [15:0] d);
        return {32'hFFFF_FFFF, st, op, phy, rg, 2'b10, d};
    endfunction

    task automatic wr_reg(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1;
        bus_addr = a;
        bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
        bus_addr = CTRL_A;
    endtask

    task automatic rd_reg(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
        bus_addr = CTRL_A;
    endtask

    // start a frame and count the cycles busy reads 1; optional write mid-frame
    task automatic run_frame(input logic [31:0] word, input bit mid_en, input logic [31:0] mid_word,
                             output int cycles);
        nrise = 0;
        seg_first = 1'b1;
        seg_min = 1_000_000;
        seg_max = 0;
        @(negedge clk);
        bus_wr = 1'b1;
        bus_addr = CTRL_A;
        bus_wdata = word;
        @(negedge clk);
        bus_wr = 1'b0;
        cycles = 0;
        while (bus_rdata[0] === 1'b1 && cycles < 20000) begin
            cycles++;
            @(negedge clk);
            if (mid_en && cycles == 100) begin
                bus_wr = 1'b1;
                bus_wdata = mid_word;
            end else begin
                bus_wr = 1'b0;
            end
        end
        bus_wr = 1'b0;
    endtask

    task automatic t_reset;
        logic [31:0] v;
        rd_reg(CTRL_A, v);
        chk(v == 32'd0, "R1 control after reset", 64'(v), 64'd0);
        rd_reg(DATA_A, v);
        chk(v == 32'd0, "R1 data after reset", 64'(v), 64'd0);
        chk(mdc == 1'b0 && mdio_oe == 1'b0, "R1 mdc/oe after reset", {62'd0, mdc, mdio_oe}, 64'd0);
    endtask

    task automatic t_short_write;
        int cyc;
        logic [63:0] e;
        wr_reg(DATA_A, 32'h0000_BEEF);
        run_frame(mkctl(3'd3, 5'h11, 5'h0A, 1'b0, 2'b01), 1'b0, '0, cyc);
        chk(cyc == 128 * 3, "R2 busy length rate 3", 64'(cyc), 64'(128 * 3));
        e = expfrm(2'b01, 2'b01, 5'h11, 5'h0A, 16'hBEEF);
        chk(cap[63:18] == e[63:18], "R3 R4 short write header", cap, e);
        chk(cap[17:0] == e[17:0], "R5 turnaround and data", cap, e);
        chk(oecap == '1, "R5 drive enable all bits", oecap, '1);
        chk(nrise == 64, "R2 64 clock periods", 64'(nrise), 64'd64);
        chk(mdio_oe == 1'b0 && mdc == 1'b0, "R10 idle after frame", {62'd0, mdc, mdio_oe}, 64'd0);
    endtask

    task automatic t_short_read;
        int cyc;
        logic [63:0] e;
        logic [31:0] v;
        resp = 16'h5A3C;
        wr_reg(DATA_A, 32'hFFFF_0000);
        run_frame(mkctl(3'd2, 5'h07, 5'h15, 1'b0, 2'b00), 1'b0, '0, cyc);
        e = expfrm(2'b01, 2'b10, 5'h07, 5'h15, 16'h0000);
        chk(cap[63:18] == e[63:18], "R3 R4 short read header", cap, e);
        chk(oecap == {46'h3FFF_FFFF_FFFF, 18'd0}, "R6 release on read", oecap, {46'h3FFF_FFFF_FFFF, 18'd0});
        rd_reg(DATA_A, v);
        chk(v == 32'h0000_5A3C, "R6 read data captured", 64'(v), 64'h5A3C);
        chk(seg_min == 5 && seg_max == 5, "R8 half period rate 2", 64'(seg_max), 64'd5);
    endtask

    task automatic t_extended;
        int cyc;
        logic [63:0] e;
        logic [31:0] v;
        wr_reg(DATA_A, 32'h0000_1234);
        run_frame(mkctl(3'd3, 5'h02, 5'h03, 1'b1, 2'b00), 1'b0, '0, cyc);
        e = expfrm(2'b00, 2'b00, 5'h02, 5'h03, 16'h1234);
        chk(cap == e && oecap == '1, "R7 extended address frame", cap, e);
        wr_reg(DATA_A, 32'h0000_CAFE);
        run_frame(mkctl(3'd3, 5'h02, 5'h03, 1'b1, 2'b01), 1'b0, '0, cyc);
        e = expfrm(2'b00, 2'b01, 5'h02, 5'h03, 16'hCAFE);
        chk(cap == e && oecap == '1, "R7 extended write frame", cap, e);
        resp = 16'h0F0F;
        run_frame(mkctl(3'd3, 5'h02, 5'h03, 1'b1, 2'b10), 1'b0, '0, cyc);
        e = expfrm(2'b00, 2'b11, 5'h02, 5'h03, 16'h0000);
        chk(cap[63:18] == e[63:18], "R7 extended read opcode", cap, e);
        chk(oecap[17:0] == 18'd0, "R7 extended read releases", oecap, 64'd0);
        rd_reg(DATA_A, v);
        chk(v == 32'h0000_0F0F, "R7 extended read data", 64'(v), 64'h0F0F);
        resp = 16'hA001;
        run_frame(mkctl(3'd3, 5'h02, 5'h03, 1'b1, 2'b11), 1'b0, '0, cyc);
        e = expfrm(2'b00, 2'b10, 5'h02, 5'h03, 16'h0000);
        chk(cap[63:18] == e[63:18], "R7 read-increment opcode", cap, e);
        rd_reg(DATA_A, v);
        chk(v == 32'h0000_A001, "R7 read-increment data", 64'(v), 64'hA001);
    endtask

    task automatic t_rates;
        int cyc;
        int exp_h;
        for (int r = 0; r < 8; r++) begin
            if (r == 2 || r == 3 || r == 6) continue;
            case (r)
                0: exp_h = 25;
                1: exp_h = 13;
                default: exp_h = 50;
            endcase
            wr_reg(DATA_A, 32'h0000_00FF);
            run_frame(mkctl(3'(r), 5'h01, 5'h01, 1'b0, 2'b01), 1'b0, '0, cyc);
            chk(seg_min == exp_h && seg_max == exp_h, $sformatf("R8 half period rate %0d", r),
                64'(seg_max), 64'(exp_h));
            chk(cyc == 128 * exp_h, $sformatf("R2 busy length rate %0d", r), 64'(cyc), 64'(128 * exp_h));
        end
    endtask

    task automatic t_busy_ignore;
        int cyc;
        logic [31:0] first;
        logic [31:0] v;
        logic [63:0] e;
        first = mkctl(3'd3, 5'h03, 5'h04, 1'b0, 2'b01);
        wr_reg(DATA_A, 32'h0000_1357);
        run_frame(first, 1'b1, mkctl(3'd1, 5'h1F, 5'h1E, 1'b1, 2'b10), cyc);
        e = expfrm(2'b01, 2'b01, 5'h03, 5'h04, 16'h1357);
        chk(cap == e, "R9 frame unchanged by busy write", cap, e);
        chk(cyc == 384, "R9 frame length unchanged", 64'(cyc), 64'd384);
        rd_reg(CTRL_A, v);
        chk(v == (first & ~32'd1), "R9 control fields kept", 64'(v), 64'(first & ~32'd1));
        repeat (40) @(negedge clk);
        chk(bus_rdata[0] == 1'b0 && nrise == 64, "R9 no second frame", 64'(nrise), 64'd64);
        chk(mdio_oe == 1'b0, "R10 released when idle", 64'(mdio_oe), 64'd0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_short_write();
        t_short_read();
        t_extended();
        t_rates();
        t_busy_ignore();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule